// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command bus of a single-data-rate SDRAM from reset until the memory can accept normal traffic. Right after reset it keeps the bus idle with clock enable and the data mask both high. This holds for a long, parameterized settling pause, so that nothing drives the data lines while the supply settles. It then closes every bank with one precharge and runs a fixed number of auto-refresh cycles.

Next it writes the mode register once. That single write carries CAS latency, burst length, burst ordering and write mode, all taken from configuration inputs. After a final settle delay it raises a done flag and parks the bus in NOP.

All delays are cycle-count parameters, so the user sizes them from the clock period. For example, 10000 cycles at 50 MHz gives a 200 µs pause. Reads, writes, periodic refresh and the data path belong to the controller that takes over once done is high.

Top module: `sdinit_seq`

## Requirements
- R1: While reset is low, the bus shows NOP (csN=0, rasN=1, casN=1, weN=1), cke=1, dqm=1 and initDone=0.
- R2: After reset is released, exactly PAUSE_CYC cycles of NOP appear before the first other command, with cke and dqm high in every one of them.
- R3: The first command after the pause is precharge-all (csN=0, rasN=0, casN=1, weN=0 with addr[10]=1). It is followed by exactly TRP_CYC NOP cycles.
- R4: Exactly REF_NUM auto-refresh commands (csN=0, rasN=0, casN=0, weN=1) follow the precharge, each followed by exactly TRC_CYC NOP cycles. The mode write comes only after the last of them.
- R5: The mode register write (csN, rasN, casN, weN all 0) happens exactly once, with ba=0. Its address carries the full mode word: burst length code in addr[2:0], interleaved ordering in addr[3], CAS latency in addr[6:4], single-write mode in addr[9], and every other bit 0.
- R6: A CAS latency input of 2 or 3 is written unchanged. Any other value is written as 3.
- R7: After the mode write, exactly TRSC_CYC NOP cycles pass before initDone rises. From then on initDone stays high, the bus stays in NOP, dqm is 0 and cke is 1.
- R8: Asserting reset at any point of the sequence returns the block to the R1 state. A later release restarts the full sequence from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| casLat | input | 3 | Requested CAS latency in cycles |
| burstLen | input | 3 | Burst length code placed in the mode word |
| burstInterleave | input | 1 | 1 selects interleaved burst ordering |
| writeSingle | input | 1 | 1 selects single-location writes |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask, high until init completes |
| addr | output | ADDR_W | Address bus (mode word, A10 for precharge-all) |
| ba | output | BANK_W | Bank address |
| initDone | output | 1 | High once the memory is ready |

## Verification
The in-line assertions check several rules on every cycle. The mode write never happens before the full refresh count. The latency field of a mode write is always 2 or 3. Once done is high it stays high and the bus is idle. The bench scenarios cover what needs a whole trace: the exact pause length, the gap after each command, the exact mode word for several configurations (including out-of-range latencies), and a restart after reset is asserted in the middle of the refresh phase.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE, ST_PRE, ST_WRP, ST_REF, ST_WRC, ST_MRS, ST_WRSC, ST_DONE
  } initState_t;

  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic issueMrs;
    logic initDone;
  } seqStrobe_t;

  // {rasN, casN, weN}; csN is low for all of them
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_REF = 3'b001;
  localparam logic [2:0] CMD_MRS = 3'b000;

endpackage

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
#(
  parameter int PAUSE_CYC = 10000,
  parameter int TRP_CYC   = 3,
  parameter int TRC_CYC   = 8,
  parameter int TRSC_CYC  = 2,
  parameter int REF_NUM   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  output seqStrobe_t strobe
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_WAIT = maxOf(maxOf(PAUSE_CYC, TRP_CYC), maxOf(TRC_CYC, TRSC_CYC));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int REF_W    = $clog2(REF_NUM + 1);

  initState_t       state, nxtState;
  logic [CNT_W-1:0] waitCnt, cntLast;
  logic [REF_W-1:0] refCnt;
  logic             waitHit;

  assign waitHit = (waitCnt == cntLast);

  always_comb begin
    nxtState = state;
    cntLast  = '0;
    case (state)
      ST_PAUSE: begin
        cntLast = CNT_W'(PAUSE_CYC - 1);
        if (waitHit) nxtState = ST_PRE;
      end
      ST_PRE:   nxtState = ST_WRP;
      ST_WRP: begin
        cntLast = CNT_W'(TRP_CYC - 1);
        if (waitHit) nxtState = ST_REF;
      end
      ST_REF:   nxtState = ST_WRC;
      ST_WRC: begin
        cntLast = CNT_W'(TRC_CYC - 1);
        if (waitHit) nxtState = (refCnt == REF_W'(REF_NUM)) ? ST_MRS : ST_REF;
      end
      ST_MRS:   nxtState = ST_WRSC;
      ST_WRSC: begin
        cntLast = CNT_W'(TRSC_CYC - 1);
        if (waitHit) nxtState = ST_DONE;
      end
      default:  nxtState = state;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PAUSE;
      waitCnt <= '0;
      refCnt  <= '0;
    end else begin
      state <= nxtState;
      if (nxtState != state)      waitCnt <= '0;
      else if (state != ST_DONE)  waitCnt <= waitCnt + 1'b1;
      if (state == ST_REF)        refCnt  <= refCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.issuePre = (state == ST_PRE);
    strobe.issueRef = (state == ST_REF);
    strobe.issueMrs = (state == ST_MRS);
    strobe.initDone = (state == ST_DONE);
  end

  // R4
  mrs_after_refs_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueMrs |-> (refCnt == REF_W'(REF_NUM)));

  // R8
  no_pause_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_PAUSE) |=> (state != ST_PAUSE));

endmodule

// File: rtl/sdinit_dp.sv
module sdinit_dp
  import sdinit_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BANK_W  = 2,
  parameter int REF_NUM = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [2:0]        casLat,
  input  logic [2:0]        burstLen,
  input  logic              burstInterleave,
  input  logic              writeSingle,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic              dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              initDone
);

  localparam int SEEN_W = $clog2(REF_NUM + 2);

  logic [2:0]        clLegal;
  logic [ADDR_W-1:0] modeWord, preWord;
  logic [2:0]        cmdNext;
  logic [ADDR_W-1:0] addrNext;

  assign clLegal = (casLat == 3'd2) ? 3'd2 : 3'd3;

  always_comb begin
    modeWord      = '0;
    modeWord[2:0] = burstLen;
    modeWord[3]   = burstInterleave;
    modeWord[6:4] = clLegal;
    modeWord[9]   = writeSingle;
    preWord       = '0;
    preWord[10]   = 1'b1;
  end

  always_comb begin
    cmdNext  = CMD_NOP;
    addrNext = '0;
    if (strobe.issuePre) begin
      cmdNext  = CMD_PRE;
      addrNext = preWord;
    end else if (strobe.issueRef) begin
      cmdNext  = CMD_REF;
    end else if (strobe.issueMrs) begin
      cmdNext  = CMD_MRS;
      addrNext = modeWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN              <= 1'b0;
      {rasN, casN, weN} <= CMD_NOP;
      cke              <= 1'b1;
      dqm              <= 1'b1;
      addr             <= '0;
      ba               <= '0;
      initDone         <= 1'b0;
    end else begin
      csN              <= 1'b0;
      {rasN, casN, weN} <= cmdNext;
      cke              <= 1'b1;
      dqm              <= ~strobe.initDone;
      addr             <= addrNext;
      ba               <= '0;
      initDone         <= strobe.initDone;
    end
  end

  // Count of refresh commands seen on the bus, for the ordering check
  logic [SEEN_W-1:0] refSeen;
  logic              busMrs, busRef;
  assign busMrs = !csN && !rasN && !casN && !weN;
  assign busRef = !csN && !rasN && !casN && weN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refSeen <= '0;
    else if (busRef && refSeen != SEEN_W'(REF_NUM + 1)) refSeen <= refSeen + 1'b1;
  end

  // R4
  mrs_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    busMrs |-> (refSeen == SEEN_W'(REF_NUM)));

  // R6
  cl_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    busMrs |-> (addr[6:4] == 3'd2 || addr[6:4] == 3'd3));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (!csN && rasN && casN && weN && cke && !dqm));

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int PAUSE_CYC = 10000,
  parameter int TRP_CYC   = 3,
  parameter int TRC_CYC   = 8,
  parameter int TRSC_CYC  = 2,
  parameter int REF_NUM   = 8,
  parameter int ADDR_W    = 12,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        casLat,
  input  logic [2:0]        burstLen,
  input  logic              burstInterleave,
  input  logic              writeSingle,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic              dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              initDone
);

  seqStrobe_t strobe;

  sdinit_ctrl #(
    .PAUSE_CYC(PAUSE_CYC), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC),
    .TRSC_CYC(TRSC_CYC), .REF_NUM(REF_NUM)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .strobe(strobe)
  );

  sdinit_dp #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .REF_NUM(REF_NUM)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .casLat(casLat), .burstLen(burstLen),
    .burstInterleave(burstInterleave), .writeSingle(writeSingle),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .dqm(dqm), .addr(addr), .ba(ba), .initDone(initDone)
  );

endmodule

// File: tb/sdinit_seq_tb.sv
module sdinit_seq_tb_top;

  localparam int PAUSE = 40;
  localparam int TRP   = 3;
  localparam int TRC   = 5;
  localparam int TRSC  = 2;
  localparam int NREF  = 8;
  localparam int AW    = 12;
  localparam int BW    = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    casLat = 3'd2, burstLen = 3'd0;
  logic          burstInterleave = 1'b0, writeSingle = 1'b0;
  logic          csN, rasN, casN, weN, cke, dqm, initDone;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  sdinit_seq #(
    .PAUSE_CYC(PAUSE), .TRP_CYC(TRP), .TRC_CYC(TRC), .TRSC_CYC(TRSC),
    .REF_NUM(NREF), .ADDR_W(AW), .BANK_W(BW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .casLat(casLat), .burstLen(burstLen),
    .burstInterleave(burstInterleave), .writeSingle(writeSingle),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .cke(cke), .dqm(dqm),
    .addr(addr), .ba(ba), .initDone(initDone)
  );

  localparam logic [3:0] BUS_NOP = 4'b0111;
  localparam logic [3:0] BUS_PRE = 4'b0010;
  localparam logic [3:0] BUS_REF = 4'b0001;
  localparam logic [3:0] BUS_MRS = 4'b0000;

  function automatic logic [3:0] bus();
    return {csN, rasN, casN, weN};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Advance and count NOP cycles until a non-NOP command or done appears
  task automatic countIdle(output int n);
    n = 0;
    @(negedge clk);
    while (bus() == BUS_NOP && !initDone && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic checkResetState(input string req);
    chk(bus() == BUS_NOP, req, "bus during reset", bus(), BUS_NOP);
    chk(cke && dqm, req, "cke,dqm during reset", {cke, dqm}, 3);
    chk(!initDone, req, "done during reset", initDone, 0);
  endtask

  // Full sequence from reset to done, with all timing and encoding checks
  task automatic runSeq(input logic [2:0] cl, input logic [2:0] bl,
                        input logic bi, input logic ws, input string rq);
    int n;
    bit hiOk;
    logic [AW-1:0] expWord;
    casLat = cl; burstLen = bl; burstInterleave = bi; writeSingle = ws;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkResetState(rq == "" ? "R1" : rq);
    @(negedge clk);
    rstN = 1'b1;
    n = 0; hiOk = 1'b1;
    @(negedge clk);
    while (bus() == BUS_NOP && n < 5000) begin
      if (!(cke && dqm)) hiOk = 1'b0;
      n++;
      @(negedge clk);
    end
    chk(n == PAUSE, "R2", "pause NOP cycles", n, PAUSE);
    chk(hiOk, "R2", "cke/dqm high in pause", hiOk, 1);
    chk(bus() == BUS_PRE && addr[10], "R3", "first command precharge-all",
        {bus(), addr[10]}, {BUS_PRE, 1'b1});
    countIdle(n);
    chk(n == TRP, "R3", "NOPs after precharge", n, TRP);
    for (int i = 0; i < NREF; i++) begin
      chk(bus() == BUS_REF, "R4", $sformatf("refresh %0d", i), bus(), BUS_REF);
      countIdle(n);
      chk(n == TRC, "R4", $sformatf("NOPs after refresh %0d", i), n, TRC);
    end
    expWord = '0;
    expWord[2:0] = bl;
    expWord[3]   = bi;
    expWord[6:4] = (cl == 3'd2) ? 3'd2 : 3'd3;
    expWord[9]   = ws;
    chk(bus() == BUS_MRS, "R5", "mode write after refreshes", bus(), BUS_MRS);
    chk(addr == expWord, "R5", "mode word", addr, expWord);
    chk(ba == '0, "R5", "mode bank", ba, 0);
    chk(addr[6:4] == expWord[6:4], "R6", $sformatf("CAS latency for input %0d", cl),
        addr[6:4], expWord[6:4]);
    countIdle(n);
    chk(n == TRSC, "R7", "NOPs before done", n, TRSC);
    chk(initDone, "R7", "done raised", initDone, 1);
    for (int i = 0; i < 6; i++) begin
      chk(initDone && bus() == BUS_NOP && !dqm && cke, "R7", "idle after done",
          {initDone, bus(), dqm, cke}, {1'b1, BUS_NOP, 1'b0, 1'b1});
      @(negedge clk);
    end
  endtask

  task automatic scenarioLat2Seq();
    runSeq(3'd2, 3'd3, 1'b0, 1'b0, "R1");
  endtask

  task automatic scenarioLat3Interleave();
    runSeq(3'd3, 3'd2, 1'b1, 1'b1, "R1");
  endtask

  task automatic scenarioIllegalLat();
    runSeq(3'd0, 3'd7, 1'b1, 1'b0, "R6");
    runSeq(3'd1, 3'd1, 1'b0, 1'b1, "R6");
    runSeq(3'd7, 3'd0, 1'b0, 1'b0, "R6");
  endtask

  task automatic scenarioMidReset();
    bit sawRef;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    sawRef = 1'b0;
    for (int i = 0; i < PAUSE + TRP + 2 * TRC + 4; i++) begin
      @(negedge clk);
      if (bus() == BUS_REF) sawRef = 1'b1;
    end
    chk(sawRef && !initDone, "R8", "in refresh phase before reset",
        {sawRef, initDone}, 2);
    runSeq(3'd3, 3'd1, 1'b0, 1'b1, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    checkResetState("R1");
    scenarioLat2Seq();
    scenarioLat3Interleave();
    scenarioIllegalLat();
    scenarioMidReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule